// File: doc/BRIEF.md
# Frequency-Select Strap Capture and Band Selection

This block owns the board pins that serve two purposes. While the system powers up they carry strap levels that pick the CPU frequency band. After power is declared good, the same pins become clock outputs. The block captures the three strap levels once, after a synchronized rising edge of the power-good input. Until that capture it keeps every shared pin's output driver off. After the capture it hands each pin's output enable to a configuration bit.

The block also produces the active CPU band code. A 2-bit source select picks one of three codes: the captured strap code, or one of two codes written by software. The chosen code is decoded into a nominal CPU frequency in MHz. If the chosen code is the reserved value, a flag is raised and the last legal code stays in effect. The captured straps are also presented for readback. Clock synthesis is handled elsewhere.

Top module: `fs_strap_ctrl`

## Requirements
- R1: After reset, `band_code_o` is 3'b101, `band_mhz_o` is 100, and `band_rsvd_o`, `strap_valid_o` and `pin_oe_o` are all zero.
- R2: `pwr_good_i` passes through a two-flop synchronizer. After it rises, `strap_valid_o` goes high on the third rising clock edge and not before. The straps are captured on that same edge.
- R3: Capture happens only once. After `strap_valid_o` is high, later pulses on `pwr_good_i` and changes on `strap_i` do not alter `strap_o`. Only reset clears `strap_valid_o` and re-arms the capture.
- R4: `strap_o` holds the captured levels as {C,B,A}: bit 2 is `strap_i[2]` (C), bit 1 is B and bit 0 is A. These are the values shown as read-only bits 7..5 of the status byte.
- R5: While `strap_valid_o` is low, `pin_oe_o` is all zero, whatever `oe_cfg_i` holds.
- R6: While `strap_valid_o` is high, each bit of `pin_oe_o` equals the matching bit of `oe_cfg_i` (0 = tristate, 1 = drive), with no added clock delay.
- R7: `band_src_i` selects the candidate code as follows: 2'b00 and 2'b11 select the captured straps {C,B,A}, 2'b01 selects `cb1_code_i`, and 2'b10 selects `cb2_code_i`. The selected code appears on `band_code_o` one clock edge later.
- R8: When the candidate code is 3'b111 (reserved), `band_rsvd_o` is high after the next edge and `band_code_o` keeps its previous value. `band_code_o` never shows 3'b111.
- R9: While `strap_valid_o` is low, choosing the strap source leaves `band_code_o` unchanged.
- R10: `band_mhz_o` decodes `band_code_o` as follows: 101 is 100, 001 is 133, 011 is 166, 010 is 200, 000 is 266, 100 is 333, and 110 is 400.
- R11: `pin_a_ref_sel_o` follows `pin_a_mode_i`. A value of 1 routes the reference clock to pin A, and 0 routes the PCI clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Asynchronous power-good indication |
| strap_i | input | 3 | Strap pin levels, [2]=C, [1]=B, [0]=A |
| band_src_i | input | 2 | Band code source select |
| cb1_code_i | input | 3 | First programmable band code |
| cb2_code_i | input | 3 | Second programmable band code |
| oe_cfg_i | input | 3 | Per-pin output enable configuration |
| pin_a_mode_i | input | 1 | Pin A clock choice: 1 reference, 0 PCI |
| band_code_o | output | 3 | Active band code |
| band_mhz_o | output | 9 | Nominal CPU frequency of the active band |
| band_rsvd_o | output | 1 | Reserved code was selected |
| strap_o | output | 3 | Captured strap levels {C,B,A} |
| strap_valid_o | output | 1 | Straps have been captured |
| pin_oe_o | output | 3 | Per-pin output enable |
| pin_a_ref_sel_o | output | 1 | Pin A clock mux select |

## Verification
The assertions check several properties on every cycle:
- the output-enable gate before capture, and the pass-through of the enables after capture;
- that the captured value and the valid flag cannot change once set;
- that the band code never shows the reserved value and holds whenever the flag is raised;
- that the valid flag can only rise two edges after power-good was seen high.

Some behaviour only the bench scenarios can show. These are the exact capture edge, the mapping of each source select to its code, and the frequency decode. They also include the re-arming of the capture by reset with new strap levels, and the hold of the code when the strap source is chosen before capture.

// File: rtl/fs_strap_pkg.sv
package fs_strap_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned MHZ_W  = 9;

  localparam logic [CODE_W-1:0] CODE_RSVD = 3'b111;
  localparam logic [CODE_W-1:0] CODE_RST  = 3'b101;

  typedef enum logic [SRC_W-1:0] {
    SRC_STRAP = 2'b00,
    SRC_CB1   = 2'b01,
    SRC_CB2   = 2'b10,
    SRC_ALT   = 2'b11
  } band_src_e;

  function automatic logic [MHZ_W-1:0] code_to_mhz(input logic [CODE_W-1:0] c);
    case (c)
      3'b101:  code_to_mhz = 9'd100;
      3'b001:  code_to_mhz = 9'd133;
      3'b011:  code_to_mhz = 9'd166;
      3'b010:  code_to_mhz = 9'd200;
      3'b000:  code_to_mhz = 9'd266;
      3'b100:  code_to_mhz = 9'd333;
      3'b110:  code_to_mhz = 9'd400;
      default: code_to_mhz = '0;
    endcase
  endfunction
endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/fs_strap_latch.sv
module fs_strap_latch #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pg_sync_i,
  input  logic [WIDTH-1:0] strap_i,
  output logic [WIDTH-1:0] strap_o,
  output logic             valid_o
);
  logic [WIDTH-1:0] strap_q;
  logic             done_q;
  logic             take;

  // one-shot: only reset re-arms
  assign take = pg_sync_i && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      done_q  <= 1'b0;
    end else if (take) begin
      strap_q <= strap_i;
      done_q  <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign valid_o = done_q;
endmodule

// File: rtl/fs_band_sel.sv
module fs_band_sel
  import fs_strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [CODE_W-1:0] strap_code_i,
  input  logic              strap_valid_i,
  input  logic [CODE_W-1:0] cb1_i,
  input  logic [CODE_W-1:0] cb2_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MHZ_W-1:0]  mhz_o,
  output logic              rsvd_o
);
  logic [CODE_W-1:0] cand;
  logic              from_strap;
  logic              cand_rsvd;
  logic              upd;
  logic [CODE_W-1:0] code_q;
  logic              rsvd_q;

  always_comb begin
    unique case (band_src_e'(src_i))
      SRC_CB1: begin cand = cb1_i;        from_strap = 1'b0; end
      SRC_CB2: begin cand = cb2_i;        from_strap = 1'b0; end
      default: begin cand = strap_code_i; from_strap = 1'b1; end
    endcase
  end

  assign cand_rsvd = (cand == CODE_RSVD);
  assign upd       = !cand_rsvd && (!from_strap || strap_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_RST;
      rsvd_q <= 1'b0;
    end else begin
      rsvd_q <= cand_rsvd;
      if (upd) code_q <= cand;
    end
  end

  assign code_o = code_q;
  assign rsvd_o = rsvd_q;
  assign mhz_o  = code_to_mhz(code_q);
endmodule

// File: rtl/fs_strap_ctrl.sv
module fs_strap_ctrl
  import fs_strap_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pwr_good_i,
  input  logic [CODE_W-1:0]   strap_i,
  input  logic [SRC_W-1:0]    band_src_i,
  input  logic [CODE_W-1:0]   cb1_code_i,
  input  logic [CODE_W-1:0]   cb2_code_i,
  input  logic [NUM_PINS-1:0] oe_cfg_i,
  input  logic                pin_a_mode_i,
  output logic [CODE_W-1:0]   band_code_o,
  output logic [MHZ_W-1:0]    band_mhz_o,
  output logic                band_rsvd_o,
  output logic [CODE_W-1:0]   strap_o,
  output logic                strap_valid_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                pin_a_ref_sel_o
);
  logic pg_sync;
  logic [CODE_W-1:0] strap_lat;
  logic strap_vld;

  fs_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_good_i),
    .q_o   (pg_sync)
  );

  fs_strap_latch #(.WIDTH(CODE_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pg_sync_i(pg_sync),
    .strap_i  (strap_i),
    .strap_o  (strap_lat),
    .valid_o  (strap_vld)
  );

  fs_band_sel u_band (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_i        (band_src_i),
    .strap_code_i (strap_lat),
    .strap_valid_i(strap_vld),
    .cb1_i        (cb1_code_i),
    .cb2_i        (cb2_code_i),
    .code_o       (band_code_o),
    .mhz_o        (band_mhz_o),
    .rsvd_o       (band_rsvd_o)
  );

  // shared pins stay undriven until straps are captured
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_oe_o[p] = strap_vld & oe_cfg_i[p];
  end

  assign strap_o         = strap_lat;
  assign strap_valid_o   = strap_vld;
  assign pin_a_ref_sel_o = pin_a_mode_i;
endmodule

// File: rtl/fs_strap_ctrl_chk.sv
module fs_strap_ctrl_chk
  import fs_strap_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pwr_good_i,
  input logic [CODE_W-1:0]   strap_i,
  input logic [SRC_W-1:0]    band_src_i,
  input logic [CODE_W-1:0]   cb1_code_i,
  input logic [CODE_W-1:0]   cb2_code_i,
  input logic [NUM_PINS-1:0] oe_cfg_i,
  input logic                pin_a_mode_i,
  input logic [CODE_W-1:0]   band_code_o,
  input logic [MHZ_W-1:0]    band_mhz_o,
  input logic                band_rsvd_o,
  input logic [CODE_W-1:0]   strap_o,
  input logic                strap_valid_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                pin_a_ref_sel_o
);
  AST_OE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_valid_o |-> (pin_oe_o == '0)); // R5
  AST_OE_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_valid_o |-> (pin_oe_o == oe_cfg_i)); // R6
  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_valid_o |=> strap_valid_o); // R3
  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_valid_o |=> $stable(strap_o)); // R3
  AST_VALID_AFTER_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strap_valid_o) |-> $past(pwr_good_i, 2)); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_code_o != CODE_RSVD); // R8
  AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_rsvd_o |-> $stable(band_code_o)); // R8
endmodule

bind fs_strap_ctrl fs_strap_ctrl_chk #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/fs_strap_ctrl_tb.sv
module fs_strap_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good_i = 1'b0;
  logic [2:0] strap_i = 3'b000;
  logic [1:0] band_src_i = 2'b00;
  logic [2:0] cb1_code_i = 3'b001;
  logic [2:0] cb2_code_i = 3'b010;
  logic [2:0] oe_cfg_i = 3'b111;
  logic pin_a_mode_i = 1'b0;
  logic [2:0] band_code_o;
  logic [8:0] band_mhz_o;
  logic band_rsvd_o;
  logic [2:0] strap_o;
  logic strap_valid_o;
  logic [2:0] pin_oe_o;
  logic pin_a_ref_sel_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fs_strap_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i), .strap_i(strap_i),
    .band_src_i(band_src_i), .cb1_code_i(cb1_code_i), .cb2_code_i(cb2_code_i),
    .oe_cfg_i(oe_cfg_i), .pin_a_mode_i(pin_a_mode_i),
    .band_code_o(band_code_o), .band_mhz_o(band_mhz_o), .band_rsvd_o(band_rsvd_o),
    .strap_o(strap_o), .strap_valid_o(strap_valid_o), .pin_oe_o(pin_oe_o),
    .pin_a_ref_sel_o(pin_a_ref_sel_o)
  );

  // {src, cb1, cb2, exp_code, exp_rsvd, exp_mhz}; straps captured as 3'b011
  localparam logic [20:0] VEC [N_VEC] = '{
    {2'b00, 3'b001, 3'b010, 3'b011, 1'b0, 9'd166},
    {2'b01, 3'b001, 3'b010, 3'b001, 1'b0, 9'd133},
    {2'b10, 3'b001, 3'b010, 3'b010, 1'b0, 9'd200},
    {2'b11, 3'b001, 3'b010, 3'b011, 1'b0, 9'd166},
    {2'b01, 3'b111, 3'b010, 3'b011, 1'b1, 9'd166},
    {2'b10, 3'b111, 3'b100, 3'b100, 1'b0, 9'd333},
    {2'b10, 3'b001, 3'b111, 3'b100, 1'b1, 9'd333},
    {2'b01, 3'b110, 3'b111, 3'b110, 1'b0, 9'd400},
    {2'b00, 3'b110, 3'b111, 3'b011, 1'b0, 9'd166},
    {2'b01, 3'b101, 3'b000, 3'b101, 1'b0, 9'd100},
    {2'b10, 3'b101, 3'b000, 3'b000, 1'b0, 9'd266}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(2);
    // R1 reset state, R5 gating with all enables requested
    chk("R1 code", band_code_o, 3'b101);
    chk("R1 mhz", band_mhz_o, 100);
    chk("R1 rsvd", band_rsvd_o, 0);
    chk("R1 valid", strap_valid_o, 0);
    chk("R5 oe in reset", pin_oe_o, 0);
    rst_ni = 1'b1;
    cyc(1);
    // R9 strap source before capture holds the code
    chk("R9 hold pre-capture", band_code_o, 3'b101);
    band_src_i = 2'b01; cb1_code_i = 3'b010;
    cyc(1);
    chk("R7 cb1 pre-capture", band_code_o, 3'b010);
    band_src_i = 2'b00;
    cyc(1);
    chk("R9 strap src pre-capture", band_code_o, 3'b010);
    chk("R5 oe pre-capture", pin_oe_o, 0);
    // R2 capture timing
    strap_i = 3'b011; cb1_code_i = 3'b001;
    pwr_good_i = 1'b1;
    cyc(2);
    chk("R2 not valid after two edges", strap_valid_o, 0);
    chk("R5 oe before valid", pin_oe_o, 0);
    cyc(1);
    chk("R2 valid on third edge", strap_valid_o, 1);
    chk("R4 strap readback", strap_o, 3'b011);
    // R6 enables pass through
    oe_cfg_i = 3'b101; #1;
    chk("R6 oe follow", pin_oe_o, 3'b101);
    oe_cfg_i = 3'b010; #1;
    chk("R6 oe follow", pin_oe_o, 3'b010);
    // R11 pin A mux
    pin_a_mode_i = 1'b1; #1;
    chk("R11 ref sel", pin_a_ref_sel_o, 1);
    pin_a_mode_i = 1'b0; #1;
    chk("R11 pci sel", pin_a_ref_sel_o, 0);
    // R7 R8 R10 table
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      band_src_i = VEC[i][20:19];
      cb1_code_i = VEC[i][18:16];
      cb2_code_i = VEC[i][15:13];
      @(negedge clk);
      chk("R7 band code", band_code_o, VEC[i][12:10]);
      chk("R8 reserved flag", band_rsvd_o, VEC[i][9]);
      chk("R10 mhz", band_mhz_o, VEC[i][8:0]);
    end
    // R3 one-shot: glitch power-good with new straps
    strap_i = 3'b100;
    pwr_good_i = 1'b0;
    cyc(4);
    pwr_good_i = 1'b1;
    cyc(5);
    chk("R3 strap frozen", strap_o, 3'b011);
    chk("R3 valid held", strap_valid_o, 1);
    band_src_i = 2'b00;
    cyc(1);
    chk("R3 band uses frozen straps", band_code_o, 3'b011);
    // R3 reset re-arms; power-good already high
    rst_ni = 1'b0;
    #1;
    chk("R1 valid cleared by reset", strap_valid_o, 0);
    chk("R5 oe cleared by reset", pin_oe_o, 0);
    cyc(1);
    rst_ni = 1'b1;
    cyc(2);
    chk("R2 no capture yet", strap_valid_o, 0);
    cyc(1);
    chk("R3 re-armed capture", strap_o, 3'b100);
    cyc(1);
    chk("R7 strap source after re-arm", band_code_o, 3'b100);
    chk("R10 mhz 333", band_mhz_o, 333);
    // R8 reserved strap code
    rst_ni = 1'b0; strap_i = 3'b111;
    cyc(1);
    rst_ni = 1'b1;
    cyc(4);
    chk("R8 reserved strap flagged", band_rsvd_o, 1);
    chk("R8 reserved strap hold", band_code_o, 3'b101);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule